// File: doc/BRIEF.md
# Boundary-Pausing Single-Address DMA Address Engine

This block generates the memory addresses for a single-address DMA transfer inside a memory-card host. Control logic loads a start address, a block size with a boundary-size code, and a block count, then pulses a start request. The engine issues one word-wide memory request per beat and advances the address by the word size on every accepted beat. After a block's worth of beats it waits for the card data path to report that the block finished, and then counts that block off.

When an accepted beat leaves the next address on an exact multiple of the boundary size (4 KiB shifted left by the boundary code), the engine stops issuing requests. It raises a sticky DMA interrupt and holds until the address register is written again. That write loads the given address and resumes the transfer. Transfer-complete is flagged after the final block. If a boundary pause is still pending at that moment, the flag waits until the resuming address write.

The memory request port is valid/ready. The engine raises `mem_req_valid` with the address and direction, and holds both unchanged until `mem_req_ready` is sampled high at a clock edge. A beat transfers on each edge where valid and ready are both high. Ready may stay low for any number of cycles. All other pins are plain level or single-cycle pulse signals.

Top module: `sdma_boundary_engine`

## Requirements
- R1: Writes to the block configuration (`cfg_blk_wdata` bits [11:0] = block size in bytes, bits [14:12] = boundary code) and to the block count are taken only while `busy` is low. A write while busy leaves `blocks_left` unchanged. `blocks_left` shows the count register.
- R2: `start` is accepted only when `start_sel` is 2'b00 (single-address mode), the block count is nonzero and the block size holds at least one word. Any other `start_sel` value (01, 10, 11) or a zero count leaves `busy` low.
- R3: Once valid, `mem_req_valid` and `mem_req_addr` hold until accepted. Beats issue from the start address in steps of WORD_BYTES. `mem_req_write` is the inverse of the direction captured from `start_rd` at start.
- R4: After block size / WORD_BYTES accepted beats, no request is issued until `blk_done` pulses. Each such pulse decrements `blocks_left` by one.
- R5: When an accepted beat makes the next address a multiple of 4096 << code, `paused` and `dma_int` go high on that same edge and `mem_req_valid` stays low while paused.
- R6: An address write while paused loads the written address, clears `paused`, and the next request uses the written address.
- R7: An address write while busy and not paused is ignored: `cur_addr` is unchanged.
- R8: `xfer_done` rises and `busy` falls on the edge that takes the final `blk_done`, unless paused. If paused, both wait for the resuming address write, and no further requests are issued.
- R9: `dma_int` and `xfer_done` are sticky until their clear pulses (`dma_int_clr`, `done_clr`). A set and a clear in the same cycle leave the flag set.
- R10: A `blk_done` pulse while requests are still outstanding in the current block is ignored: `blocks_left` is unchanged.
- R11: While paused, `cur_addr` shows the next address to be used: the boundary address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_wr | input | 1 | Address register write strobe |
| cfg_addr_wdata | input | AW | Address write value |
| cfg_blk_wr | input | 1 | Block configuration write strobe |
| cfg_blk_wdata | input | 16 | [11:0] block bytes, [14:12] boundary code |
| cfg_cnt_wr | input | 1 | Block count write strobe |
| cfg_cnt_wdata | input | CW | Block count value |
| start | input | 1 | Start pulse |
| start_sel | input | 2 | DMA mode select, only 2'b00 is run |
| start_rd | input | 1 | 1 = card-to-memory (memory writes) is not set; see R3 |
| dma_int_clr | input | 1 | Clear pulse for `dma_int` |
| done_clr | input | 1 | Clear pulse for `xfer_done` |
| blk_done | input | 1 | Data path finished a block |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Request byte address |
| mem_req_write | output | 1 | 1 = memory write request |
| cur_addr | output | AW | Address register value |
| blocks_left | output | CW | Block count register value |
| paused | output | 1 | Halted at a boundary |
| busy | output | 1 | Transfer in progress |
| dma_int | output | 1 | Sticky boundary interrupt status |
| xfer_done | output | 1 | Sticky transfer-complete status |

## Verification
Each result has a fixed due time. The next address, `paused`, `dma_int` and the drop of `mem_req_valid` are all due on the same edge that accepts the crossing beat. The `blocks_left` decrement and `xfer_done` are due on the edge that samples `blk_done` or the resuming address write. Stimulus is driven on falling edges and held over exactly one rising edge, and every result is read on the following falling edge. The bench therefore expects each change exactly one rising edge after its cause. Requests are compared beat by beat against a running expected address, including under alternating back-pressure.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_BLKW = 2'd2,
    ST_FIN  = 2'd3
  } sdma_state_e;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam int BLK_SIZE_W = 12;
  localparam int BND_CODE_W = 3;
endpackage

// File: rtl/sdma_addr_unit.sv
module sdma_addr_unit #(
  parameter int AW              = 32,
  parameter int WORD_BYTES      = 4,
  parameter int BOUND_BASE_LOG2 = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [AW-1:0]                  load_val,
  input  logic                           step,
  input  logic [sdma_pkg::BND_CODE_W-1:0] bnd_code,
  output logic [AW-1:0]                  addr,
  output logic                           hit_next
);
  localparam logic [AW-1:0] STEP_V = AW'(WORD_BYTES);
  localparam logic [AW-1:0] ONE_V  = AW'(1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] nxt;
  logic [AW-1:0] span;
  logic [AW-1:0] span_mask;

  assign nxt       = addr_q + STEP_V;
  assign span      = ONE_V << (BOUND_BASE_LOG2 + int'(bnd_code));
  assign span_mask = span - ONE_V;
  assign hit_next  = ((nxt & span_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= nxt;
  end

  assign addr = addr_q;

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q == $past(addr_q) + STEP_V));
endmodule

// File: rtl/sdma_count_unit.sv
module sdma_count_unit #(
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            idle,
  input  logic                            blk_wr,
  input  logic [15:0]                     blk_wdata,
  input  logic                            cnt_wr,
  input  logic [CW-1:0]                   cnt_wdata,
  input  logic                            word_load,
  input  logic                            word_step,
  input  logic                            blk_step,
  output logic [sdma_pkg::BND_CODE_W-1:0] bnd_code,
  output logic                            words_nz,
  output logic                            last_word,
  output logic                            blk_nz,
  output logic                            last_blk,
  output logic [CW-1:0]                   blk_left
);
  import sdma_pkg::*;
  localparam int WB_LOG2 = $clog2(WORD_BYTES);

  logic [BLK_SIZE_W-1:0] size_q;
  logic [BND_CODE_W-1:0] code_q;
  logic [CW-1:0]         blk_q;
  logic [BLK_SIZE_W-1:0] word_q;
  logic [BLK_SIZE_W-1:0] words_per_blk;
  logic                  cnt_take;

  assign words_per_blk = size_q >> WB_LOG2;
  assign cnt_take      = cnt_wr && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      code_q <= '0;
    end else if (blk_wr && idle) begin
      size_q <= blk_wdata[BLK_SIZE_W-1:0];
      code_q <= blk_wdata[BLK_SIZE_W +: BND_CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blk_q <= '0;
    else if (cnt_take) blk_q <= cnt_wdata;
    else if (blk_step) blk_q <= blk_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (word_load) word_q <= words_per_blk;
    else if (word_step) word_q <= word_q - BLK_SIZE_W'(1);
  end

  assign bnd_code  = code_q;
  assign words_nz  = (words_per_blk != '0);
  assign last_word = (word_q == BLK_SIZE_W'(1));
  assign blk_nz    = (blk_q != '0);
  assign last_blk  = (blk_q == CW'(1));
  assign blk_left  = blk_q;

  // R4
  blk_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_take |=> (blk_q <= $past(blk_q)));
endmodule

// File: rtl/sdma_seq_fsm.sv
module sdma_seq_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] start_sel,
  input  logic       start_rd,
  input  logic       blk_nz,
  input  logic       words_nz,
  input  logic       beat,
  input  logic       last_word,
  input  logic       last_blk,
  input  logic       hit_next,
  input  logic       blk_done,
  input  logic       addr_wr,
  input  logic       dma_int_clr,
  input  logic       done_clr,
  output logic       idle,
  output logic       req_en,
  output logic       dir_wr,
  output logic       word_load,
  output logic       word_step,
  output logic       blk_step,
  output logic       addr_load,
  output logic       paused,
  output logic       dma_int,
  output logic       xfer_done
);
  import sdma_pkg::*;

  sdma_state_e st_q, st_d;
  logic paused_q, paused_d;
  logic int_q, done_q, dir_q;
  logic start_ok, resume, int_set, done_set;

  assign idle     = (st_q == ST_IDLE);
  assign start_ok = idle && start && (start_sel == MODE_SINGLE) && blk_nz && words_nz;
  assign resume   = paused_q && addr_wr;
  assign req_en   = (st_q == ST_XFER) && !paused_q;
  assign addr_load = addr_wr && (idle || paused_q);
  assign word_step = beat;

  always_comb begin
    st_d      = st_q;
    paused_d  = paused_q;
    word_load = 1'b0;
    blk_step  = 1'b0;
    int_set   = 1'b0;
    done_set  = 1'b0;
    if (resume) paused_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d      = ST_XFER;
          word_load = 1'b1;
          paused_d  = 1'b0;
        end
      end
      ST_XFER: begin
        if (beat) begin
          if (last_word) st_d = ST_BLKW;
          if (hit_next) begin
            paused_d = 1'b1;
            int_set  = 1'b1;
          end
        end
      end
      ST_BLKW: begin
        if (blk_done) begin
          blk_step = 1'b1;
          if (last_blk) begin
            if (paused_q && !resume) st_d = ST_FIN;
            else begin
              st_d     = ST_IDLE;
              done_set = 1'b1;
            end
          end else begin
            st_d      = ST_XFER;
            word_load = 1'b1;
          end
        end
      end
      ST_FIN: begin
        if (resume) begin
          st_d     = ST_IDLE;
          done_set = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      paused_q <= 1'b0;
      int_q    <= 1'b0;
      done_q   <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      paused_q <= paused_d;
      if (int_set)          int_q  <= 1'b1;
      else if (dma_int_clr) int_q  <= 1'b0;
      if (done_set)         done_q <= 1'b1;
      else if (done_clr)    done_q <= 1'b0;
      if (start_ok)         dir_q  <= !start_rd;
    end
  end

  assign dir_wr    = dir_q;
  assign paused    = paused_q;
  assign dma_int   = int_q;
  assign xfer_done = done_q;

  // R5
  pause_raises_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_q) |-> int_q);
  // R8
  done_not_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !paused_q);
  // R8
  idle_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != ST_IDLE && st_q == ST_IDLE) |-> done_q);
endmodule

// File: rtl/sdma_boundary_engine.sv
module sdma_boundary_engine #(
  parameter int AW              = 32,
  parameter int CW              = 16,
  parameter int WORD_BYTES      = 4,
  parameter int BOUND_BASE_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_addr_wr,
  input  logic [AW-1:0] cfg_addr_wdata,
  input  logic          cfg_blk_wr,
  input  logic [15:0]   cfg_blk_wdata,
  input  logic          cfg_cnt_wr,
  input  logic [CW-1:0] cfg_cnt_wdata,
  input  logic          start,
  input  logic [1:0]    start_sel,
  input  logic          start_rd,
  input  logic          dma_int_clr,
  input  logic          done_clr,
  input  logic          blk_done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_write,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] blocks_left,
  output logic          paused,
  output logic          busy,
  output logic          dma_int,
  output logic          xfer_done
);
  logic idle, req_en, dir_wr, word_load, word_step, blk_step, addr_load;
  logic hit_next, words_nz, last_word, blk_nz, last_blk, beat;
  logic [sdma_pkg::BND_CODE_W-1:0] bnd_code;
  logic [AW-1:0] addr;

  assign beat = req_en && mem_req_ready;

  sdma_addr_unit #(.AW(AW), .WORD_BYTES(WORD_BYTES), .BOUND_BASE_LOG2(BOUND_BASE_LOG2)) addr_u (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(cfg_addr_wdata),
    .step(beat), .bnd_code(bnd_code), .addr(addr), .hit_next(hit_next));

  sdma_count_unit #(.CW(CW), .WORD_BYTES(WORD_BYTES)) cnt_u (
    .clk(clk), .rst_n(rst_n), .idle(idle), .blk_wr(cfg_blk_wr), .blk_wdata(cfg_blk_wdata),
    .cnt_wr(cfg_cnt_wr), .cnt_wdata(cfg_cnt_wdata), .word_load(word_load),
    .word_step(word_step), .blk_step(blk_step), .bnd_code(bnd_code), .words_nz(words_nz),
    .last_word(last_word), .blk_nz(blk_nz), .last_blk(last_blk), .blk_left(blocks_left));

  sdma_seq_fsm seq_u (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sel(start_sel), .start_rd(start_rd),
    .blk_nz(blk_nz), .words_nz(words_nz), .beat(beat), .last_word(last_word),
    .last_blk(last_blk), .hit_next(hit_next), .blk_done(blk_done), .addr_wr(cfg_addr_wr),
    .dma_int_clr(dma_int_clr), .done_clr(done_clr), .idle(idle), .req_en(req_en),
    .dir_wr(dir_wr), .word_load(word_load), .word_step(word_step), .blk_step(blk_step),
    .addr_load(addr_load), .paused(paused), .dma_int(dma_int), .xfer_done(xfer_done));

  assign mem_req_valid = req_en;
  assign mem_req_addr  = addr;
  assign mem_req_write = dir_wr;
  assign cur_addr      = addr;
  assign busy          = !idle;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R5
  no_req_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_req_valid);
endmodule

// File: tb/sdma_boundary_engine_tb_top.sv
module sdma_boundary_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_addr_wr = 0, cfg_blk_wr = 0, cfg_cnt_wr = 0, start = 0, start_rd = 0;
  logic [31:0] cfg_addr_wdata = '0;
  logic [15:0] cfg_blk_wdata = '0, cfg_cnt_wdata = '0;
  logic [1:0]  start_sel = '0;
  logic dma_int_clr = 0, done_clr = 0, blk_done = 0, mem_req_ready = 0;
  logic mem_req_valid, mem_req_write, paused, busy, dma_int, xfer_done;
  logic [31:0] mem_req_addr, cur_addr;
  logic [15:0] blocks_left;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdma_boundary_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr_wr(cfg_addr_wr), .cfg_addr_wdata(cfg_addr_wdata),
    .cfg_blk_wr(cfg_blk_wr), .cfg_blk_wdata(cfg_blk_wdata), .cfg_cnt_wr(cfg_cnt_wr),
    .cfg_cnt_wdata(cfg_cnt_wdata), .start(start), .start_sel(start_sel), .start_rd(start_rd),
    .dma_int_clr(dma_int_clr), .done_clr(done_clr), .blk_done(blk_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_write(mem_req_write), .cur_addr(cur_addr), .blocks_left(blocks_left),
    .paused(paused), .busy(busy), .dma_int(dma_int), .xfer_done(xfer_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [31:0] a);
    @(negedge clk); cfg_addr_wr = 1; cfg_addr_wdata = a;
    @(negedge clk); cfg_addr_wr = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] c);
    @(negedge clk); cfg_cnt_wr = 1; cfg_cnt_wdata = c;
    @(negedge clk); cfg_cnt_wr = 0;
  endtask

  task automatic setup(input logic [31:0] a, input logic [15:0] blk, input logic [15:0] c);
    @(negedge clk);
    cfg_addr_wr = 1; cfg_addr_wdata = a;
    cfg_blk_wr = 1; cfg_blk_wdata = blk;
    cfg_cnt_wr = 1; cfg_cnt_wdata = c;
    @(negedge clk);
    cfg_addr_wr = 0; cfg_blk_wr = 0; cfg_cnt_wr = 0;
  endtask

  task automatic go(input logic [1:0] sel, input logic rd);
    @(negedge clk); start = 1; start_sel = sel; start_rd = rd;
    @(negedge clk); start = 0; start_sel = 2'b00;
  endtask

  task automatic pulse_blk();
    @(negedge clk); blk_done = 1;
    @(negedge clk); blk_done = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); dma_int_clr = 1; done_clr = 1;
    @(negedge clk); dma_int_clr = 0; done_clr = 0;
  endtask

  task automatic pump(input int n, input logic [31:0] a0, input bit bp, input string req);
    int got = 0;
    int cyc = 0;
    logic [31:0] exp = a0;
    while (got < n && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      mem_req_ready = bp ? cyc[0] : 1'b1;
      #1;
      if (mem_req_valid && mem_req_ready) begin
        check(req, mem_req_addr, exp);
        exp += 32'd4;
        got++;
      end
    end
    @(negedge clk);
    mem_req_ready = 0;
    check({req, " beat count"}, got, n);
  endtask

  task automatic t_reset();
    check("R1 reset blocks_left", blocks_left, 0);
    check("R8 reset busy", busy, 0);
    check("R3 reset valid", mem_req_valid, 0);
    check("R9 reset flags", {dma_int, xfer_done, paused}, 0);
    check("R11 reset cur_addr", cur_addr, 0);
  endtask

  task automatic t_basic();
    setup(32'h100, 16'h0010, 16'd2);
    go(2'b00, 1'b0);
    check("R2 start accepted", busy, 1);
    check("R3 write direction", mem_req_write, 1);
    pump(4, 32'h100, 0, "R3 block0 addr");
    repeat (2) @(negedge clk);
    check("R4 wait blk_done", mem_req_valid, 0);
    wr_addr(32'hABC0);
    check("R7 busy addr write ignored", cur_addr, 32'h110);
    wr_cnt(16'd9);
    check("R1 busy count write ignored", blocks_left, 2);
    pulse_blk();
    check("R4 count decrement", blocks_left, 1);
    pump(4, 32'h110, 0, "R3 block1 addr");
    pulse_blk();
    check("R8 done after last", {busy, xfer_done}, 2'b01);
    check("R4 count zero", blocks_left, 0);
    repeat (3) @(negedge clk);
    check("R9 done sticky", xfer_done, 1);
    clear_flags();
    check("R9 done cleared", xfer_done, 0);
  endtask

  task automatic t_backpressure();
    setup(32'h2000, 16'h0020, 16'd1);
    go(2'b00, 1'b1);
    check("R3 read direction", mem_req_write, 0);
    pulse_blk();
    check("R10 early blk_done ignored", blocks_left, 1);
    pump(8, 32'h2000, 1, "R3 backpressure addr");
    check("R5 no pause off-boundary", paused, 0);
    pulse_blk();
    check("R8 done bp", xfer_done, 1);
    clear_flags();
  endtask

  task automatic t_boundary();
    setup(32'h0FF0, 16'h0020, 16'd1);
    go(2'b00, 1'b0);
    pump(4, 32'h0FF0, 0, "R3 pre-boundary addr");
    check("R5 paused", {paused, dma_int}, 2'b11);
    check("R11 next addr", cur_addr, 32'h1000);
    repeat (3) @(negedge clk);
    check("R5 no request while paused", mem_req_valid, 0);
    @(negedge clk); dma_int_clr = 1;
    @(negedge clk); dma_int_clr = 0;
    check("R9 int cleared", dma_int, 0);
    check("R5 still paused", paused, 1);
    wr_addr(32'h5000);
    check("R6 resume", paused, 0);
    pump(4, 32'h5000, 0, "R6 resumed addr");
    pulse_blk();
    check("R8 done after resume", xfer_done, 1);
    clear_flags();
  endtask

  task automatic t_deferred();
    setup(32'h1FF0, 16'h0010, 16'd1);
    go(2'b00, 1'b0);
    pump(4, 32'h1FF0, 0, "R5 last beat addr");
    check("R5 pause at block end", paused, 1);
    pulse_blk();
    check("R4 last count", blocks_left, 0);
    check("R8 done deferred", {busy, xfer_done}, 2'b10);
    wr_addr(32'h2000);
    check("R8 done on resume", {busy, xfer_done, paused}, 3'b010);
    repeat (3) @(negedge clk);
    check("R8 no requests after", mem_req_valid, 0);
    clear_flags();
  endtask

  task automatic t_code();
    setup(32'h0FF8, 16'h1010, 16'd1);
    go(2'b00, 1'b0);
    pump(4, 32'h0FF8, 0, "R5 code1 crossing 4K");
    check("R5 code1 no 4K pause", paused, 0);
    pulse_blk();
    clear_flags();
    setup(32'h1FF8, 16'h1010, 16'd1);
    go(2'b00, 1'b0);
    pump(2, 32'h1FF8, 0, "R5 code1 addr");
    check("R5 code1 8K pause", paused, 1);
    check("R11 code1 next", cur_addr, 32'h2000);
    wr_addr(32'h2000);
    pump(2, 32'h2000, 0, "R6 code1 resumed");
    pulse_blk();
    check("R8 code1 done", xfer_done, 1);
    clear_flags();
  endtask

  task automatic t_reject();
    setup(32'h300, 16'h0010, 16'd1);
    go(2'b01, 1'b0);
    check("R2 sel01 rejected", busy, 0);
    go(2'b10, 1'b0);
    check("R2 sel10 rejected", busy, 0);
    go(2'b11, 1'b0);
    check("R2 sel11 rejected", busy, 0);
    wr_cnt(16'd0);
    go(2'b00, 1'b0);
    check("R2 zero count rejected", busy, 0);
    wr_cnt(16'd1);
    check("R1 idle count write", blocks_left, 1);
    go(2'b00, 1'b0);
    check("R2 sel00 accepted", busy, 1);
    pump(4, 32'h300, 0, "R3 reject-test addr");
    pulse_blk();
    check("R8 reject-test done", xfer_done, 1);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_boundary();
    t_deferred();
    t_code();
    t_reject();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule